// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block is the processor-side port of an interrupt controller. The distributor offers it one candidate per cycle: an interrupt number and a priority value. The port checks that candidate against its enable bit, its priority threshold and its own record of interrupts already in service. It then drives a single request line to the processor.

The processor takes an interrupt by reading the acknowledge register. That read returns the interrupt number and marks the interrupt as in service. In the same cycle the port pulses an acknowledge strobe carrying the number, so that the distributor can drop its pending state. When the handler finishes, software writes the same number to the end-of-interrupt register, and the interrupt becomes eligible again. A read that finds nothing eligible returns the reserved "nothing to service" number, 1023.

The register port is a simple single-cycle strobe interface. Read data is registered and is returned one cycle after the read strobe, together with a valid flag. Register select (`bus_addr_i`): 0 = control, 1 = priority threshold, 2 = acknowledge (read only), 3 = end-of-interrupt (write only).

Top module: `irqc_cpu_port`

## Requirements
- R1: After reset the request line and acknowledge strobe are low, control and threshold read as 0, no interrupt is in service, and an acknowledge read returns 1023.
- R2: Control bit 0 enables signalling. While it is 0 the request line is low one cycle later and acknowledge reads return 1023. A candidate still offered when the bit is set again raises the request line one cycle later.
- R3: A candidate qualifies when it is valid, its priority is numerically less than the threshold, it is not in service, and the port is enabled. The request line follows qualification one cycle later.
- R4: A candidate whose priority equals or exceeds the threshold does not qualify.
- R5: An acknowledge read of a qualifying candidate returns its number in bits [9:0], with the upper bits zero, on the cycle after the read. In that same cycle `ack_valid_o` is high and `ack_id_o` carries the number. The interrupt is then in service, and the request line is low from that cycle.
- R6: An acknowledge read with no qualifying candidate returns 1023, raises no acknowledge strobe and changes no state.
- R7: A candidate that is in service neither raises the request line nor can be acknowledged again.
- R8: An end-of-interrupt write of an in-service number takes it out of service, so that a still-offered candidate with that number requests again.
- R9: An end-of-interrupt write is ignored in either of two cases: the number is not in service, or any write-data bit above bit 9 is set.
- R10: Control bit 0 and the 8-bit threshold read back as written. Other control bits read as 0.
- R11: Candidate numbers above 1020 or not below the number of supported interrupts never qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt number |
| cand_prio_i | input | PRIO_W | Candidate priority, lower is more urgent |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Acknowledge strobe towards the distributor |
| ack_id_o | output | 10 | Number just acknowledged |

## Verification
The assertions rely on three properties of the inputs. First, the read and write strobes are never raised together. Second, the distributor's candidate is stable for at least one full cycle before the request line or an acknowledge is judged. Third, the candidate changes only between clock edges. The bench meets all three by driving every input on the falling edge, by issuing one register access per task, and by letting one clock pass after changing the candidate before it checks the request line. Out-of-range numbers are offered only as candidates or as end-of-interrupt data, which is where the rules for them apply.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [ID_W-1:0] MAX_ID      = 10'd1020;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      mask_o <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_CTRL)  en_o   <= wdata_i[0];
      if (addr_i == REG_PMASK) mask_o <= wdata_i;
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_o) && $stable(mask_o)); // R10
endmodule

// File: rtl/irqc_active.sv
module irqc_active
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic [ID_W-1:0] set_id_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] clr_id_i,
  input  logic [ID_W-1:0] look_id_i,
  output logic            look_hit_o,
  output logic            clr_hit_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] active_q;

  function automatic logic in_range(input logic [ID_W-1:0] id);
    return (int'(id) < NUM_IRQ) && (id <= MAX_ID);
  endfunction

  assign look_hit_o = in_range(look_id_i) && active_q[look_id_i[IDX_W-1:0]];
  assign clr_hit_o  = clr_i && in_range(clr_id_i) && active_q[clr_id_i[IDX_W-1:0]];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        active_q[g] <= 1'b0;
      else if (set_i && (set_id_i == ID_W'(g)))
        active_q[g] <= 1'b1;
      else if (clr_hit_o && (clr_id_i == ID_W'(g)))
        active_q[g] <= 1'b0;
    end
  end

  AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    set_i |=> active_q[$past(set_id_i[IDX_W-1:0])]); // R5
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (rst)
    clr_hit_o && !set_i |=> !active_q[$past(clr_id_i[IDX_W-1:0])]); // R8
  AST_EOI_NOOP: assert property (@(posedge clk) disable iff (rst)
    clr_i && !clr_hit_o && !set_i |=> $stable(active_q)); // R9
endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              cand_active_i,
  input  logic              ack_fire_i,
  output logic              qual_o,
  output logic              irq_o
);
  logic id_ok;

  assign id_ok  = (int'(cand_id_i) < NUM_IRQ) && (cand_id_i <= MAX_ID);
  assign qual_o = en_i && cand_valid_i && id_ok && !cand_active_i &&
                  (cand_prio_i < mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= qual_o && !ack_fire_i;
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_o); // R2
  AST_MASK_STRICT: assert property (@(posedge clk) disable iff (rst)
    (cand_prio_i >= mask_i) |=> !irq_o); // R4
  AST_ACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cand_active_i |=> !irq_o); // R7
endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid_i,
  input  logic [9:0]        cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o,
  output logic              ack_valid_o,
  output logic [9:0]        ack_id_o
);
  logic              en;
  logic [PRIO_W-1:0] mask;
  logic              qual;
  logic              cand_active;
  logic              ack_fire;
  logic              eoi_req;
  logic              eoi_hit;
  logic              upper_clear;
  logic [DATA_W-1:0] rd_next;

  assign upper_clear = ~|bus_wdata_i[DATA_W-1:ID_W];
  assign ack_fire    = bus_rd_i && (bus_addr_i == REG_ACK) && qual;
  assign eoi_req     = bus_wr_i && (bus_addr_i == REG_EOI) && upper_clear;

  irqc_regs #(.PRIO_W(PRIO_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i[PRIO_W-1:0]),
    .en_o    (en),
    .mask_o  (mask)
  );

  irqc_active #(.NUM_IRQ(NUM_IRQ)) active_i (
    .clk        (clk),
    .rst        (rst),
    .set_i      (ack_fire),
    .set_id_i   (cand_id_i),
    .clr_i      (eoi_req),
    .clr_id_i   (bus_wdata_i[ID_W-1:0]),
    .look_id_i  (cand_id_i),
    .look_hit_o (cand_active),
    .clr_hit_o  (eoi_hit)
  );

  irqc_qualify #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) qual_i (
    .clk           (clk),
    .rst           (rst),
    .en_i          (en),
    .mask_i        (mask),
    .cand_valid_i  (cand_valid_i),
    .cand_id_i     (cand_id_i),
    .cand_prio_i   (cand_prio_i),
    .cand_active_i (cand_active),
    .ack_fire_i    (ack_fire),
    .qual_o        (qual),
    .irq_o         (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_CTRL:  rd_next = DATA_W'(en);
      REG_PMASK: rd_next = DATA_W'(mask);
      REG_ACK:   rd_next = qual ? DATA_W'(cand_id_i) : DATA_W'(SPURIOUS_ID);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
      ack_valid_o  <= 1'b0;
      ack_id_o     <= '0;
    end else begin
      bus_rvalid_o <= bus_rd_i;
      ack_valid_o  <= ack_fire;
      if (bus_rd_i) bus_rdata_o <= rd_next;
      if (ack_fire) ack_id_o    <= cand_id_i;
    end
  end

  AST_SPURIOUS_ID: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid_o && !ack_valid_o && ($past(bus_addr_i) == REG_ACK)
      |-> bus_rdata_o == DATA_W'(SPURIOUS_ID)); // R6
  AST_ACK_ECHO: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> bus_rvalid_o && (bus_rdata_o == DATA_W'(ack_id_o)) && !irq_o); // R5
  AST_ACK_RANGE: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> (ack_id_o <= MAX_ID) && (int'(ack_id_o) < NUM_IRQ)); // R11
  AST_EOI_GATED: assert property (@(posedge clk) disable iff (rst)
    eoi_hit |-> upper_clear); // R9
endmodule

// File: tb/irqc_cpu_port_tb_top.sv
`timescale 1ns/1ps
module irqc_cpu_port_tb_top;
  localparam int NUM_IRQ = 64;
  localparam int PRIO_W  = 8;
  localparam int DATA_W  = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              cand_valid;
  logic [9:0]        cand_id;
  logic [PRIO_W-1:0] cand_prio;
  logic              bus_wr, bus_rd;
  logic [1:0]        bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid, irq, ack_valid;
  logic [9:0]        ack_id;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irqc_cpu_port #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .cand_valid_i(cand_valid), .cand_id_i(cand_id),
    .cand_prio_i(cand_prio), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .irq_o(irq), .ack_valid_o(ack_valid), .ack_id_o(ack_id)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [PRIO_W-1:0] p);
    cand_valid = v; cand_id = id; cand_prio = p;
    step();
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    check("R1 irq after reset", irq, 0);
    check("R1 ack strobe after reset", ack_valid, 0);
    reg_rd(2'd0, d); check("R1 ctrl reset", d, 0);
    reg_rd(2'd1, d); check("R1 threshold reset", d, 0);
    reg_rd(2'd2, d); check("R1 ack reset value", d, 1023);
  endtask

  task automatic t_regs();
    logic [DATA_W-1:0] d;
    reg_wr(2'd0, 32'hFFFF_FFFE);
    reg_rd(2'd0, d); check("R10 ctrl upper bits ignored", d, 0);
    reg_wr(2'd0, 32'h1);
    reg_rd(2'd0, d); check("R10 ctrl readback", d, 1);
    reg_wr(2'd1, 32'h0000_01F0);
    reg_rd(2'd1, d); check("R10 threshold readback", d, 32'hF0);
  endtask

  task automatic t_ack_flow();
    logic [DATA_W-1:0] d;
    offer(1'b1, 10'd37, 8'h40);
    check("R3 irq on qualifying candidate", irq, 1);
    reg_rd(2'd2, d);
    check("R5 ack returns id", d, 37);
    check("R5 ack strobe", ack_valid, 1);
    check("R5 ack id", ack_id, 37);
    check("R5 irq drops on ack", irq, 0);
    step();
    check("R7 active not requested", irq, 0);
    reg_rd(2'd2, d);
    check("R7 active not acknowledged", d, 1023);
    check("R6 no strobe on spurious", ack_valid, 0);
    reg_wr(2'd3, 32'd12);
    reg_wr(2'd3, 32'h0000_0425);
    step();
    check("R9 ignored eoi keeps irq low", irq, 0);
    reg_rd(2'd2, d);
    check("R9 ignored eoi keeps active", d, 1023);
    reg_wr(2'd3, 32'd37);
    step();
    check("R8 eoi re-enables request", irq, 1);
    reg_rd(2'd2, d);
    check("R8 second ack returns id", d, 37);
    reg_wr(2'd3, 32'd37);
    offer(1'b0, 10'd0, 8'h00);
    check("R6 no candidate irq low", irq, 0);
    reg_rd(2'd2, d);
    check("R6 empty ack", d, 1023);
  endtask

  task automatic t_threshold();
    logic [DATA_W-1:0] d;
    reg_wr(2'd1, 32'h80);
    offer(1'b1, 10'd9, 8'h80);
    check("R4 equal priority blocked", irq, 0);
    reg_rd(2'd2, d);
    check("R4 equal priority ack", d, 1023);
    offer(1'b1, 10'd9, 8'h7F);
    check("R3 below threshold requests", irq, 1);
    offer(1'b0, 10'd0, 8'h00);
  endtask

  task automatic t_enable();
    logic [DATA_W-1:0] d;
    offer(1'b1, 10'd50, 8'h10);
    check("R2 enabled request", irq, 1);
    reg_wr(2'd0, 32'h0);
    step();
    check("R2 disabled irq low", irq, 0);
    reg_rd(2'd2, d);
    check("R2 disabled ack spurious", d, 1023);
    reg_wr(2'd0, 32'h1);
    step();
    check("R2 level delivered after re-enable", irq, 1);
    offer(1'b0, 10'd0, 8'h00);
  endtask

  task automatic t_range();
    logic [DATA_W-1:0] d;
    offer(1'b1, 10'd1021, 8'h00);
    check("R11 id above 1020", irq, 0);
    reg_rd(2'd2, d);
    check("R11 id above 1020 ack", d, 1023);
    offer(1'b1, 10'd64, 8'h00);
    check("R11 id beyond table", irq, 0);
    offer(1'b1, 10'd63, 8'h00);
    check("R11 top valid id", irq, 1);
    reg_rd(2'd2, d);
    check("R11 top valid id ack", d, 63);
    offer(1'b1, 10'd5, 8'h01);
    reg_rd(2'd2, d);
    check("R5 second active id", d, 5);
    reg_wr(2'd3, 32'd63);
    offer(1'b1, 10'd63, 8'h00);
    check("R8 one retire leaves other active", irq, 1);
    offer(1'b1, 10'd5, 8'h01);
    check("R7 other stays active", irq, 0);
    reg_wr(2'd3, 32'd5);
    step();
    check("R8 second retire", irq, 1);
    offer(1'b0, 10'd0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cand_valid = 1'b0; cand_id = '0; cand_prio = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ack_flow();
    t_threshold();
    reg_wr(2'd1, 32'hF0);
    t_enable();
    t_range();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule